// File: doc/BRIEF.md
# Interrupt Controller Claim/Complete Register File

This block is the register side of a platform interrupt controller that serves several target contexts. Each interrupt source has a level input, a pending bit that follows that level, a claimed bit and a priority. Each context has its own enable words and its own priority threshold. For each context a priority selector finds the best source that is pending, not claimed, enabled, and above the context's threshold. The selector drives the context's interrupt output.

Software uses a single 32-bit port with a select, a write enable, an address and write data. Read data is registered and returns one cycle after the request. A handler reads the context's claim/complete word to take the best source. That read clears the source's pending bit and marks the source claimed, so the source is not presented again. When service is done, the handler writes the same ID back to release the source. The base addresses and the power-of-two strides are parameters.

Top module: `plic_regfile`

## Requirements
- R1: While reset is high at a clock edge, all priorities, thresholds, enables, pending bits and claimed bits clear. After that edge every context interrupt output is 0, read data is 0, and every register reads back 0.
- R2: The priority of source i sits at PRIO_BASE + 4*i. It reads back zero-extended. When PRIO_MAX+1 is a power of two, a write stores the value modulo PRIO_MAX+1. Otherwise a write above PRIO_MAX is dropped and the old value stays.
- R3: The threshold of context c sits at offset 0 of the window CTX_BASE + c*CTX_STRIDE. It uses the same write filter as R2.
- R4: At each clock edge the pending bit of a source takes the level of its input, unless R8 clears it. Pending bits are read as 32-bit words at PEND_BASE + 4*w, with source i in bit i%32 of word i/32. Writes to this region have no effect.
- R5: Enable word w of context c sits at EN_BASE + c*EN_STRIDE + 4*w. Bit i%32 of word i/32 enables source i. An offset whose word index is at or above ceil(N_SRC/32) ignores writes and reads 0.
- R6: A context output is high exactly when some source with ID 1..N_SRC-1 meets four conditions: it is pending, it is not claimed, it is enabled in that context, and its priority is strictly above the context threshold. Source 0 is never presented.
- R7: A read of offset 4 in a context window returns, one cycle later, the qualifying source with the highest priority. On a tie the lowest ID wins. The read returns 0 when no source qualifies.
- R8: A claim read that returns a nonzero ID clears that source's pending bit and sets its claimed bit at the same clock edge. The clear wins over a high input level in that cycle. The source is not presented to any context while it stays claimed.
- R9: A write of value v to offset 4 of a context window clears the claimed bit of source v if v < N_SRC. A write with v >= N_SRC has no effect.
- R10: Reads of unmapped addresses return 0, and writes to them have no effect. In a context window this includes every offset other than 0 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lvl | input | N_SRC | Level of each interrupt source |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 32 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| ctx_irq | output | N_CTX | Interrupt request to each context |

## Verification
The assertions rely on a few conditions at the inputs. Addresses are word aligned. At most one access happens per cycle, so a claim and a completion never share an edge. Reset is held from time zero. The bench only drives aligned addresses. Each access is placed on a falling edge for exactly one cycle. A random phase draws addresses only from word-aligned offsets, both inside and just outside each region. It also toggles source levels freely, including in the same cycle as a claim.

// File: rtl/plic_pkg.sv
package plic_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } region_e;

    typedef struct packed {
        region_e     rg;
        logic [15:0] ctx;
        logic [15:0] idx;
    } decode_t;

    // Filter a priority or threshold write against the legal range.
    function automatic logic [31:0] legalize(input logic [31:0] wval,
                                             input logic [31:0] old,
                                             input int unsigned pmax);
        logic [31:0] span;
        span = 32'(pmax) + 32'd1;
        if ((span & 32'(pmax)) == 32'd0)
            return wval % span;
        else if (wval <= 32'(pmax))
            return wval;
        else
            return old;
    endfunction

endpackage

// File: rtl/plic_pick.sv
module plic_pick #(
    parameter int N_SRC = 40,
    parameter int PW    = 3,
    parameter int IDW   = 6
) (
    input  logic [N_SRC-1:0]    cand_i,
    input  logic [N_SRC*PW-1:0] prio_i,
    input  logic [PW-1:0]       thr_i,
    output logic [IDW-1:0]      id_o,
    output logic                hit_o
);
    logic [PW-1:0] best;

    // Strict compare keeps the lowest ID on a tie.
    always_comb begin
        best = thr_i;
        id_o = '0;
        for (int i = 1; i < N_SRC; i++) begin
            if (cand_i[i] && (prio_i[i*PW +: PW] > best)) begin
                best = prio_i[i*PW +: PW];
                id_o = IDW'(i);
            end
        end
        hit_o = (id_o != '0);
    end
endmodule

// File: rtl/plic_srcbits.sv
module plic_srcbits #(
    parameter int N_SRC = 40,
    parameter int IDW   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] lvl_i,
    input  logic             clr_vld,
    input  logic [IDW-1:0]   clr_id,
    input  logic             cmpl_vld,
    input  logic [IDW-1:0]   cmpl_id,
    output logic [N_SRC-1:0] pend_o,
    output logic [N_SRC-1:0] claimed_o
);
    logic [N_SRC-1:0] clr_oh;

    always_comb begin
        clr_oh = '0;
        if (clr_vld) clr_oh[clr_id] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o    <= '0;
            claimed_o <= '0;
        end else begin
            pend_o <= lvl_i & ~clr_oh;
            if (clr_vld)  claimed_o[clr_id]  <= 1'b1;
            if (cmpl_vld) claimed_o[cmpl_id] <= 1'b0;
        end
    end

    assert_pend_follow_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend_o & ~$past(clr_oh)) == ($past(lvl_i) & ~$past(clr_oh))));

    assert_claim_marks_R8: assert property (@(posedge clk) disable iff (rst)
        clr_vld |=> (!pend_o[$past(clr_id)] && claimed_o[$past(clr_id)]));

    assert_complete_R9: assert property (@(posedge clk) disable iff (rst)
        (cmpl_vld && !clr_vld) |=> !claimed_o[$past(cmpl_id)]);
endmodule

// File: rtl/plic_regfile.sv
module plic_regfile #(
    parameter int          N_SRC      = 40,
    parameter int          N_CTX      = 2,
    parameter int          PRIO_MAX   = 7,
    parameter logic [31:0] PRIO_BASE  = 32'h0000_0000,
    parameter logic [31:0] PEND_BASE  = 32'h0000_1000,
    parameter logic [31:0] EN_BASE    = 32'h0000_2000,
    parameter logic [31:0] EN_STRIDE  = 32'h0000_0080,
    parameter logic [31:0] CTX_BASE   = 32'h0000_4000,
    parameter logic [31:0] CTX_STRIDE = 32'h0000_1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_lvl,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [31:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic [N_CTX-1:0] ctx_irq
);
    import plic_pkg::*;

    localparam int NWORDS = (N_SRC + 31) / 32;
    localparam int PW     = (PRIO_MAX < 2) ? 1 : $clog2(PRIO_MAX + 1);
    localparam int IDW    = $clog2(N_SRC);
    localparam int CW     = (N_CTX > 1) ? $clog2(N_CTX) : 1;
    localparam int WW     = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int EN_SH  = $clog2(EN_STRIDE);
    localparam int CX_SH  = $clog2(CTX_STRIDE);
    localparam logic [31:0] PRIO_SPAN = 32'(N_SRC * 4);
    localparam logic [31:0] PEND_SPAN = 32'(NWORDS * 4);
    localparam logic [31:0] EN_SPAN   = 32'(N_CTX) * EN_STRIDE;
    localparam logic [31:0] CX_SPAN   = 32'(N_CTX) * CTX_STRIDE;

    logic [PW-1:0]          prio_q [N_SRC];
    logic [PW-1:0]          thr_q  [N_CTX];
    logic [31:0]            en_q   [N_CTX][NWORDS];
    logic [N_SRC-1:0]       pend, clm;
    logic [N_SRC*PW-1:0]    prio_flat;
    logic [NWORDS*32-1:0]   en_flat [N_CTX];
    logic [NWORDS*32-1:0]   pend_pad;
    logic [N_SRC-1:0]       cand [N_CTX];
    logic [IDW-1:0]         sel_id [N_CTX];
    decode_t                dec;
    logic [31:0]            off_p, off_q, off_e, off_c, sub_e, sub_c;
    logic [CW-1:0]          cx;
    logic [IDW-1:0]         src_ix;
    logic [WW-1:0]          word_ix;
    logic                   rd_go, wr_go, claim_go, claim_set, cmpl_go;
    logic [IDW-1:0]         claim_id;
    logic [31:0]            rd_val;

    // Address decode
    always_comb begin
        off_p = bus_addr - PRIO_BASE;
        off_q = bus_addr - PEND_BASE;
        off_e = bus_addr - EN_BASE;
        off_c = bus_addr - CTX_BASE;
        sub_e = off_e & (EN_STRIDE - 32'd1);
        sub_c = off_c & (CTX_STRIDE - 32'd1);
        dec   = '{rg: RG_NONE, ctx: '0, idx: '0};
        if (bus_addr >= PRIO_BASE && off_p < PRIO_SPAN) begin
            dec.rg  = RG_PRIO;
            dec.idx = 16'(off_p >> 2);
        end else if (bus_addr >= PEND_BASE && off_q < PEND_SPAN) begin
            dec.rg  = RG_PEND;
            dec.idx = 16'(off_q >> 2);
        end else if (bus_addr >= EN_BASE && off_e < EN_SPAN) begin
            dec.ctx = 16'(off_e >> EN_SH);
            dec.idx = 16'(sub_e >> 2);
            if ((sub_e >> 2) < 32'(NWORDS)) dec.rg = RG_EN;
        end else if (bus_addr >= CTX_BASE && off_c < CX_SPAN) begin
            dec.ctx = 16'(off_c >> CX_SH);
            if (sub_c == 32'd0)      dec.rg = RG_THR;
            else if (sub_c == 32'd4) dec.rg = RG_CLAIM;
        end
    end

    assign cx       = dec.ctx[CW-1:0];
    assign src_ix   = dec.idx[IDW-1:0];
    assign word_ix  = dec.idx[WW-1:0];
    assign rd_go    = bus_sel && !bus_we;
    assign wr_go    = bus_sel && bus_we;
    assign claim_go = rd_go && (dec.rg == RG_CLAIM);
    assign claim_id = sel_id[cx];
    assign claim_set = claim_go && (claim_id != '0);
    assign cmpl_go  = wr_go && (dec.rg == RG_CLAIM) && (bus_wdata < 32'(N_SRC));

    // Flattened views feeding the selectors
    always_comb begin
        pend_pad = '0;
        pend_pad[N_SRC-1:0] = pend;
        for (int i = 0; i < N_SRC; i++) prio_flat[i*PW +: PW] = prio_q[i];
        for (int c = 0; c < N_CTX; c++) begin
            for (int w = 0; w < NWORDS; w++) en_flat[c][w*32 +: 32] = en_q[c][w];
            cand[c] = pend & ~clm & en_flat[c][N_SRC-1:0];
        end
    end

    plic_srcbits #(.N_SRC(N_SRC), .IDW(IDW)) u_bits (
        .clk      (clk),
        .rst      (rst),
        .lvl_i    (irq_lvl),
        .clr_vld  (claim_set),
        .clr_id   (claim_id),
        .cmpl_vld (cmpl_go),
        .cmpl_id  (bus_wdata[IDW-1:0]),
        .pend_o   (pend),
        .claimed_o(clm)
    );

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        plic_pick #(.N_SRC(N_SRC), .PW(PW), .IDW(IDW)) u_pick (
            .cand_i(cand[c]),
            .prio_i(prio_flat),
            .thr_i (thr_q[c]),
            .id_o  (sel_id[c]),
            .hit_o (ctx_irq[c])
        );

        assert_pick_legal_R6: assert property (@(posedge clk) disable iff (rst)
            ctx_irq[c] |-> (cand[c][sel_id[c]] && (prio_q[sel_id[c]] > thr_q[c])));
    end

    // Read mux
    always_comb begin
        unique case (dec.rg)
            RG_PRIO:  rd_val = 32'(prio_q[src_ix]);
            RG_PEND:  rd_val = pend_pad[32*word_ix +: 32];
            RG_EN:    rd_val = en_q[cx][word_ix];
            RG_THR:   rd_val = 32'(thr_q[cx]);
            RG_CLAIM: rd_val = 32'(claim_id);
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_go ? rd_val : '0;
    end

    // Register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SRC; i++) prio_q[i] <= '0;
            for (int c = 0; c < N_CTX; c++) begin
                thr_q[c] <= '0;
                for (int w = 0; w < NWORDS; w++) en_q[c][w] <= '0;
            end
        end else if (wr_go) begin
            case (dec.rg)
                RG_PRIO: prio_q[src_ix] <=
                    PW'(legalize(bus_wdata, 32'(prio_q[src_ix]), PRIO_MAX));
                RG_THR:  thr_q[cx] <=
                    PW'(legalize(bus_wdata, 32'(thr_q[cx]), PRIO_MAX));
                RG_EN:   en_q[cx][word_ix] <= bus_wdata;
                default: ;
            endcase
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (ctx_irq == '0 && bus_rdata == '0));

    assert_empty_claim_R7: assert property (@(posedge clk) disable iff (rst)
        (claim_go && !claim_set) |=> (bus_rdata == '0));
endmodule

// File: tb/plic_regfile_tb.sv
module plic_regfile_tb;
    localparam int CLK_NS = 10;
    localparam int N  = 40;
    localparam int C  = 2;
    localparam int P  = 7;
    localparam int NW = 2;

    logic          clk = 0;
    logic          rst = 1;
    logic [N-1:0]  lvl = '0;
    logic          b_sel = 0, b_we = 0;
    logic [31:0]   b_addr = '0, b_wdata = '0;
    logic [31:0]   b_rdata;
    logic [C-1:0]  irq;

    int nchk = 0, nerr = 0;
    bit done = 0, started = 0;

    always #(CLK_NS/2) clk = ~clk;

    plic_regfile #(.N_SRC(N), .N_CTX(C), .PRIO_MAX(P)) u_dut (
        .clk(clk), .rst(rst), .irq_lvl(lvl), .bus_sel(b_sel), .bus_we(b_we),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(b_rdata), .ctx_irq(irq));

    // ---------------- behavioural reference model ----------------
    int unsigned m_prio[N];
    int unsigned m_thr[C];
    int unsigned m_en[C][NW];
    bit          m_pend[N];
    bit          m_clm[N];
    int unsigned m_rdata;
    string       m_tag = "R1";

    function automatic int unsigned m_legal(int unsigned v, int unsigned old);
        if (((P + 1) & P) == 0) return v % (P + 1);
        return (v <= P) ? v : old;
    endfunction

    function automatic int m_pick(int c);
        int unsigned best = m_thr[c];
        int id = 0;
        for (int i = 1; i < N; i++)
            if (m_pend[i] && !m_clm[i] && m_en[c][i/32][i%32] && m_prio[i] > best) begin
                best = m_prio[i];
                id = i;
            end
        return id;
    endfunction

    // kind: 0 none, 1 priority, 2 pending, 3 enable, 4 threshold, 5 claim
    task automatic m_decode(input int unsigned a, output int kind, output int cx, output int ix);
        kind = 0; cx = 0; ix = 0;
        if (a < N*4) begin kind = 1; ix = a/4; end
        else if (a >= 'h1000 && a < 'h1000 + NW*4) begin kind = 2; ix = (a-'h1000)/4; end
        else if (a >= 'h2000 && a < 'h2000 + C*'h80) begin
            cx = (a-'h2000)/'h80; ix = ((a-'h2000)%'h80)/4;
            if (ix < NW) kind = 3;
        end else if (a >= 'h4000 && a < 'h4000 + C*'h1000) begin
            cx = (a-'h4000)/'h1000;
            if ((a-'h4000)%'h1000 == 0) kind = 4;
            else if ((a-'h4000)%'h1000 == 4) kind = 5;
        end
    endtask

    always @(posedge clk) begin
        int kind, cx, ix, cid;
        int unsigned rv;
        started = 1;
        if (rst) begin
            foreach (m_prio[i]) begin m_prio[i] = 0; m_pend[i] = 0; m_clm[i] = 0; end
            for (int c = 0; c < C; c++) begin
                m_thr[c] = 0;
                for (int w = 0; w < NW; w++) m_en[c][w] = 0;
            end
            m_rdata = 0; m_tag = "R1";
        end else begin
            m_decode(b_addr, kind, cx, ix);
            rv = 0; cid = 0;
            if (b_sel && !b_we) begin
                case (kind)
                    1: rv = m_prio[ix];
                    2: for (int b = 0; b < 32; b++) if (ix*32+b < N) rv[b] = m_pend[ix*32+b];
                    3: rv = m_en[cx][ix];
                    4: rv = m_thr[cx];
                    5: begin cid = m_pick(cx); rv = cid; end
                    default: rv = 0;
                endcase
                m_tag = (kind == 1) ? "R2" : (kind == 2) ? "R4" : (kind == 3) ? "R5" :
                        (kind == 4) ? "R3" : (kind == 5) ? "R7" : "R10";
            end
            for (int i = 0; i < N; i++) m_pend[i] = lvl[i];
            if (cid != 0) begin m_pend[cid] = 0; m_clm[cid] = 1; end
            if (b_sel && b_we) begin
                case (kind)
                    1: m_prio[ix] = m_legal(b_wdata, m_prio[ix]);
                    3: m_en[cx][ix] = b_wdata;
                    4: m_thr[cx] = m_legal(b_wdata, m_thr[cx]);
                    5: if (b_wdata < N) m_clm[b_wdata] = 0;
                    default: ;
                endcase
            end
            m_rdata = rv;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(bit ok, string tag, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            for (int c = 0; c < C; c++)
                chk(irq[c] == (m_pick(c) != 0), "R6", irq[c], m_pick(c) != 0);
            chk(b_rdata == m_rdata, m_tag, b_rdata, m_rdata);
        end
    end

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
        b_sel = 1; b_we = 0; b_addr = a;
        @(negedge clk);
        b_sel = 0;
        chk(b_rdata == exp, tag, b_rdata, exp);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        b_sel = 1; b_we = 1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_sel = 0; b_we = 0;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cyc(3);
        rst = 0;
        // R1: reset state
        chk(irq == '0, "R1", irq, 0);
        rd(32'h14, 0, "R1");
        rd(32'h2000, 0, "R1");
        rd(32'h4004, 0, "R1");
        // R2 / R3: filtered writes
        wr(32'h14, 13);      rd(32'h14, 5, "R2");
        wr(32'h14, 3);       rd(32'h14, 3, "R2");
        wr(32'h4000, 9);     rd(32'h4000, 1, "R3");
        wr(32'h5000, 3);     rd(32'h5000, 3, "R3");
        wr(32'h5000, 7);
        // R4: pending follows level, read-only
        lvl[5] = 1; lvl[33] = 1;
        cyc(1);
        rd(32'h1000, 32'h20, "R4");
        rd(32'h1004, 32'h2, "R4");
        wr(32'h1000, 0);
        rd(32'h1000, 32'h20, "R4");
        chk(irq == '0, "R6", irq, 0);
        // R5: enables and out-of-range word
        wr(32'h2000, 32'h20);
        wr(32'h2008, 32'hFFFF);
        rd(32'h2008, 0, "R5");
        rd(32'h2000, 32'h20, "R5");
        rd(32'h2080, 0, "R5");
        // R6: presented once enabled above threshold
        chk(irq == 2'b01, "R6", irq, 2'b01);
        // R7 / R8: claim
        rd(32'h4004, 5, "R7");
        chk(irq[0] == 0, "R8", irq[0], 0);
        rd(32'h1000, 0, "R8");
        rd(32'h1000, 32'h20, "R8");
        cyc(2);
        chk(irq[0] == 0, "R8", irq[0], 0);
        // R9: completion
        wr(32'h4004, 45);
        chk(irq[0] == 0, "R9", irq[0], 0);
        wr(32'h4004, 5);
        chk(irq[0] == 1, "R9", irq[0], 1);
        // R7: tie and higher priority
        lvl[7] = 1; wr(32'h1C, 3); wr(32'h2000, 32'hA0);
        rd(32'h4004, 5, "R7");
        wr(32'h4004, 5);
        lvl[9] = 1; wr(32'h24, 6); wr(32'h2000, 32'h2A0);
        rd(32'h4004, 9, "R7");
        rd(32'h4004, 5, "R7");
        rd(32'h4004, 7, "R7");
        rd(32'h4004, 0, "R7");
        // R10: unmapped
        rd(32'h3000, 0, "R10");
        wr(32'h4008, 7);
        rd(32'h4008, 0, "R10");
        wr(32'h3000, 1);
        rd(32'h1008, 0, "R10");
        // random phase against the model
        for (int k = 0; k < 4000; k++) begin
            int unsigned r = $urandom % 12;
            if ($urandom % 4 == 0) lvl[$urandom % N] = $urandom % 2;
            b_sel = (r < 10); b_we = $urandom % 2;
            b_wdata = $urandom % 16;
            case (r)
                0, 1: b_addr = 4 * ($urandom % (N + 2));
                2:    b_addr = 32'h1000 + 4 * ($urandom % 3);
                3, 4: b_addr = 32'h2000 + 32'h80 * ($urandom % C) + 4 * ($urandom % 3);
                5:    b_addr = 32'h4000 + 32'h1000 * ($urandom % C);
                6, 7: begin
                    b_addr = 32'h4004 + 32'h1000 * ($urandom % C);
                    b_wdata = $urandom % (N + 8);
                end
                8:    b_addr = 32'h4008 + 32'h1000 * ($urandom % C);
                default: b_addr = 32'h3000 + 4 * ($urandom % 4);
            endcase
            @(negedge clk);
        end
        b_sel = 0;
        cyc(2);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule